// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block supervises a processor through a watchdog input. Software shows it is alive by toggling `wdi_i`, and either edge counts. If no toggle arrives within the selected timeout, the block asserts its paired reset outputs for one reset period. It also drops `wdo_o`, which stays low until software toggles `wdi_i` again. A low `pwr_good_i` holds the reset outputs asserted. When it returns high, one complete reset period elapses before the outputs release.

Time is counted in steps, and a two-bit mode input picks where the steps come from. In the two tick-based modes a step is one pulse of the millisecond strobe `ms_tick_i`. In the external-clock mode a step is one rising edge of `ext_clk_i`, after that pin passes through a synchronizer. After any reset the first timeout can be longer than the timeouts that follow a toggle. If `wdi_i` never moves, the block resets again after every timeout period and does not stay in reset. All periods are parameters. The defaults give 1600/200 ms, 1600 then 100 / 200 ms, and 4096 then 1024 / 2048 clocks.

Top module: `wdsup_top`

## Requirements
- R1: `rst_no` is always the inverse of `rst_o`. After `rst_ni` is released, `rst_o`=1, `rst_no`=0 and `wdo_o`=1.
- R2: While `pwr_good_i`=0, `rst_o` is 1 from the next clock edge onward. After `pwr_good_i` rises, `rst_o` stays 1 for exactly one reset period: 200 ticks in modes 00/01/11, or 2048 external rising edges in mode 10.
- R3: In mode 00 every watchdog timeout is 1600 ticks. This holds for the first timeout after reset and for every later one.
- R4: In mode 01 the first timeout after any reset is 1600 ticks. Once a `wdi_i` transition has been seen, the timeout is 100 ticks.
- R5: In mode 10 only rising edges of `ext_clk_i` advance time, and `ms_tick_i` has no effect. The reset lasts 2048 edges, the first timeout 4096 edges and later timeouts 1024 edges.
- R6: A timeout sets `rst_o`=1 and `wdo_o`=0 on the same edge, and the reset then lasts one reset period.
- R7: `wdo_o` stays 0 after a timeout until the next transition of `wdi_i`, rising or falling. It then returns to 1 within 4 clocks.
- R8: Each `wdi_i` transition restarts the timeout count. A `wdi_i` that toggles faster than the timeout never causes a reset.
- R9: While `wdi_i` is held constant, a reset pulse recurs once per timeout period.
- R10: The watchdog count is held at zero while reset is asserted. After reset releases, a full timeout elapses before the next reset.
- R11: Mode code 11 behaves as mode 00: after a `wdi_i` transition the timeout is 1600 ticks, not 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| pwr_good_i | input | 1 | Supply good; low forces reset |
| mode_i | input | 2 | Timing scheme: 00 standard, 01 fast, 10 external clock, 11 as 00 |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| ext_clk_i | input | 1 | Asynchronous external timing clock |
| wdi_i | input | 1 | Watchdog kick input, either edge |
| rst_o | output | 1 | Reset, active high |
| rst_no | output | 1 | Reset, active low |
| wdo_o | output | 1 | Watchdog flag, low after a timeout |

## Verification
The hardest situation to reach from the ports is the short timeout in mode 01. It only applies once a `wdi_i` transition has cleared the post-reset long window, so the stimulus releases reset and waits past 100 ticks without a reset. It then toggles `wdi_i` once and checks that the reset falls on the exact tick 100 ticks after the synchronized edge. The external-clock mode is reached by driving whole `ext_clk_i` periods that are slow relative to the system clock. With `ms_tick_i` held high throughout, each reset or timeout edge can be placed on a precise external-edge count.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
   typedef enum logic [1:0] {
      MODE_STD  = 2'b00,
      MODE_FAST = 2'b01,
      MODE_EXT  = 2'b10,
      MODE_ALT  = 2'b11
   } wd_mode_e;
endpackage

// File: rtl/wdsup_sync_edge.sv
module wdsup_sync_edge #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RISE_ONLY = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic edge_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("wdsup_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   if (RISE_ONLY) begin : g_rise
      assign edge_o = chain_q[STAGES-1] & ~last_q;

      // R5: a rising-edge step lasts a single cycle
      assert_step_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         edge_o |=> !edge_o);
   end else begin : g_any
      assign edge_o = chain_q[STAGES-1] ^ last_q;
   end
endmodule

// File: rtl/wdsup_period_sel.sv
module wdsup_period_sel
   import wdsup_pkg::*;
#(
   parameter int unsigned CW          = 13,
   parameter int unsigned STD_WD      = 1600,
   parameter int unsigned FAST_WD     = 100,
   parameter int unsigned TICK_RST    = 200,
   parameter int unsigned EXT_FIRST   = 4096,
   parameter int unsigned EXT_WD      = 1024,
   parameter int unsigned EXT_RST     = 2048
) (
   input  logic [1:0]    mode_i,
   input  logic          first_i,
   output logic [CW-1:0] wd_limit_o,
   output logic [CW-1:0] rst_limit_o,
   output logic          use_ext_o
);
   always_comb begin
      unique case (wd_mode_e'(mode_i))
         MODE_FAST: begin
            wd_limit_o  = first_i ? CW'(STD_WD) : CW'(FAST_WD);
            rst_limit_o = CW'(TICK_RST);
            use_ext_o   = 1'b0;
         end
         MODE_EXT: begin
            wd_limit_o  = first_i ? CW'(EXT_FIRST) : CW'(EXT_WD);
            rst_limit_o = CW'(EXT_RST);
            use_ext_o   = 1'b1;
         end
         default: begin
            wd_limit_o  = CW'(STD_WD);
            rst_limit_o = CW'(TICK_RST);
            use_ext_o   = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/wdsup_core.sv
module wdsup_core #(
   parameter int unsigned CW = 13
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          pwr_good_i,
   input  logic          step_i,
   input  logic          kick_i,
   input  logic [CW-1:0] wd_limit_i,
   input  logic [CW-1:0] rst_limit_i,
   output logic          rst_active_o,
   output logic          wdo_o,
   output logic          first_o
);
   logic          rst_q;
   logic          wdo_q;
   logic          first_q;
   logic [CW-1:0] rcnt_q;
   logic [CW-1:0] wcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rst_q   <= 1'b1;
         wdo_q   <= 1'b1;
         first_q <= 1'b1;
         rcnt_q  <= '0;
         wcnt_q  <= '0;
      end else begin
         if (kick_i) wdo_q <= 1'b1;
         if (!pwr_good_i) begin
            rst_q   <= 1'b1;
            first_q <= 1'b1;
            rcnt_q  <= '0;
            wcnt_q  <= '0;
         end else if (rst_q) begin
            wcnt_q <= '0;
            if (step_i) begin
               if (rcnt_q >= rst_limit_i - 1'b1) begin
                  rst_q  <= 1'b0;
                  rcnt_q <= '0;
               end else begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
         end else if (kick_i) begin
            wcnt_q  <= '0;
            first_q <= 1'b0;
         end else if (step_i) begin
            if (wcnt_q >= wd_limit_i - 1'b1) begin
               rst_q   <= 1'b1;
               wdo_q   <= 1'b0;
               first_q <= 1'b1;
               wcnt_q  <= '0;
            end else begin
               wcnt_q <= wcnt_q + 1'b1;
            end
         end
      end
   end

   assign rst_active_o = rst_q;
   assign wdo_o        = wdo_q;
   assign first_o      = first_q;

   assert_pg_forces_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_i |=> rst_q);

   assert_count_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_q |-> (wcnt_q == '0));

   assert_wdo_falls_in_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wdo_q) |-> rst_q);

   assert_wdo_rises_on_kick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wdo_q) |-> $past(kick_i));
endmodule

// File: rtl/wdsup_top.sv
module wdsup_top #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STD_WD      = 1600,
   parameter int unsigned FAST_WD     = 100,
   parameter int unsigned TICK_RST    = 200,
   parameter int unsigned EXT_FIRST   = 4096,
   parameter int unsigned EXT_WD      = 1024,
   parameter int unsigned EXT_RST     = 2048
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pwr_good_i,
   input  logic [1:0] mode_i,
   input  logic       ms_tick_i,
   input  logic       ext_clk_i,
   input  logic       wdi_i,
   output logic       rst_o,
   output logic       rst_no,
   output logic       wdo_o
);
   localparam int unsigned MAX_A  = (STD_WD > TICK_RST) ? STD_WD : TICK_RST;
   localparam int unsigned MAX_B  = (EXT_FIRST > EXT_RST) ? EXT_FIRST : EXT_RST;
   localparam int unsigned MAX_V  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CW     = $clog2(MAX_V + 1);

   if (FAST_WD == 0 || FAST_WD > STD_WD) begin : g_bad_fast
      $error("wdsup_top: FAST_WD must be nonzero and not above STD_WD");
   end
   if (EXT_WD == 0 || EXT_WD > EXT_FIRST) begin : g_bad_ext
      $error("wdsup_top: EXT_WD must be nonzero and not above EXT_FIRST");
   end
   if (TICK_RST == 0 || EXT_RST == 0) begin : g_bad_rst
      $error("wdsup_top: reset periods must be nonzero");
   end

   logic          kick;
   logic          ext_step;
   logic          step;
   logic          use_ext;
   logic          first;
   logic          rst_active;
   logic [CW-1:0] wd_limit;
   logic [CW-1:0] rst_limit;

   wdsup_sync_edge #(.STAGES(SYNC_STAGES), .RISE_ONLY(1'b0)) u_kick_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (wdi_i),
      .edge_o (kick)
   );

   wdsup_sync_edge #(.STAGES(SYNC_STAGES), .RISE_ONLY(1'b1)) u_ext_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ext_clk_i),
      .edge_o (ext_step)
   );

   wdsup_period_sel #(
      .CW(CW), .STD_WD(STD_WD), .FAST_WD(FAST_WD), .TICK_RST(TICK_RST),
      .EXT_FIRST(EXT_FIRST), .EXT_WD(EXT_WD), .EXT_RST(EXT_RST)
   ) u_sel (
      .mode_i      (mode_i),
      .first_i     (first),
      .wd_limit_o  (wd_limit),
      .rst_limit_o (rst_limit),
      .use_ext_o   (use_ext)
   );

   assign step = use_ext ? ext_step : ms_tick_i;

   wdsup_core #(.CW(CW)) u_core (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pwr_good_i   (pwr_good_i),
      .step_i       (step),
      .kick_i       (kick),
      .wd_limit_i   (wd_limit),
      .rst_limit_i  (rst_limit),
      .rst_active_o (rst_active),
      .wdo_o        (wdo_o),
      .first_o      (first)
   );

   assign rst_o  = rst_active;
   assign rst_no = ~rst_active;
endmodule

// File: tb/wdsup_top_bench.sv
module wdsup_top_bench;
   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       pwr_good = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       tick = 1'b1;
   logic       ext_clk = 1'b0;
   logic       wdi = 1'b0;
   logic       rst_o, rst_no, wdo_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   wdsup_top u_wdsup_top (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .pwr_good_i (pwr_good),
      .mode_i     (mode),
      .ms_tick_i  (tick),
      .ext_clk_i  (ext_clk),
      .wdi_i      (wdi),
      .rst_o      (rst_o),
      .rst_no     (rst_no),
      .wdo_o      (wdo_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic check_rst(input string tag, input int exp);
      check(tag, int'(rst_o), exp);
      check({tag, " R1 complement"}, int'(rst_no), 1 - exp);
   endtask

   task automatic ext_periods(input int n);
      repeat (n) begin
         ext_clk = 1'b1;
         wait_cyc(2);
         ext_clk = 1'b0;
         wait_cyc(2);
      end
   endtask

   task automatic power_cycle(input logic [1:0] m);
      pwr_good = 1'b0;
      mode = m;
      wait_cyc(3);
      pwr_good = 1'b1;
   endtask

   task automatic t_reset_state;
      wait_cyc(2);
      check_rst("R1 reset state rst", 1);
      check("R1 reset state wdo", int'(wdo_o), 1);
   endtask

   task automatic t_std_stuck;
      power_cycle(2'b00);
      wait_cyc(199);
      check_rst("R2 reset held at 199", 1);
      wait_cyc(1);
      check_rst("R2 reset released at 200", 0);
      wait_cyc(1599);
      check_rst("R3 R10 no timeout at 1599", 0);
      wait_cyc(1);
      check_rst("R3 timeout at 1600", 1);
      check("R6 wdo low on timeout", int'(wdo_o), 0);
      wait_cyc(199);
      check_rst("R6 pulse held at 199", 1);
      wait_cyc(1);
      check_rst("R6 pulse ends at 200", 0);
      check("R7 wdo still low without kick", int'(wdo_o), 0);
      wait_cyc(1599);
      check_rst("R9 quiet before repeat", 0);
      wait_cyc(1);
      check_rst("R9 repeated pulse", 1);
      wdi = ~wdi;
      wait_cyc(4);
      check("R7 wdo high after rising kick", int'(wdo_o), 1);
      wait_cyc(200);
      check_rst("R6 released after pulse", 0);
   endtask

   task automatic t_std_kick;
      for (int i = 0; i < 5; i++) begin
         wdi = ~wdi;
         wait_cyc(400);
         check_rst("R8 kicks prevent reset", 0);
      end
      wdi = ~wdi;
      wait_cyc(1590);
      check_rst("R8 count restarted by kick", 0);
      wait_cyc(20);
      check_rst("R3 timeout after last kick", 1);
      check("R6 wdo low", int'(wdo_o), 0);
      wdi = ~wdi;
      wait_cyc(4);
      check("R7 wdo high after falling kick", int'(wdo_o), 1);
   endtask

   task automatic t_fast;
      power_cycle(2'b01);
      wait_cyc(200);
      check_rst("R2 fast mode release", 0);
      wait_cyc(150);
      check_rst("R4 first timeout is long", 0);
      wdi = ~wdi;
      wait_cyc(102);
      check_rst("R4 short timeout not yet", 0);
      wait_cyc(1);
      check_rst("R4 short timeout at 100", 1);
      wait_cyc(200);
      check_rst("R6 fast reset period", 0);
      wait_cyc(150);
      check_rst("R4 long again after reset", 0);
      for (int i = 0; i < 10; i++) begin
         wdi = ~wdi;
         wait_cyc(60);
      end
      check_rst("R8 fast kicks prevent reset", 0);
   endtask

   task automatic t_alt_code;
      power_cycle(2'b11);
      wait_cyc(200);
      wdi = ~wdi;
      wait_cyc(150);
      check_rst("R11 code 11 not short", 0);
      wait_cyc(1452);
      check_rst("R11 before 1600", 0);
      wait_cyc(1);
      check_rst("R11 timeout at 1600", 1);
   endtask

   task automatic t_pg_drop;
      power_cycle(2'b00);
      wait_cyc(200);
      check_rst("R2 running", 0);
      pwr_good = 1'b0;
      wait_cyc(1);
      check_rst("R2 low power-good forces reset", 1);
      wait_cyc(500);
      check_rst("R2 held while power-good low", 1);
      pwr_good = 1'b1;
      wait_cyc(199);
      check_rst("R2 full period after rise", 1);
      wait_cyc(1);
      check_rst("R2 release after rise", 0);
   endtask

   task automatic t_ext;
      power_cycle(2'b10);
      tick = 1'b1;
      wait_cyc(500);
      check_rst("R5 ticks ignored in ext mode", 1);
      ext_periods(2047);
      check_rst("R5 ext reset at 2047", 1);
      ext_periods(1);
      check_rst("R5 ext reset ends at 2048", 0);
      ext_periods(4095);
      check_rst("R5 first ext timeout not yet", 0);
      ext_periods(1);
      check_rst("R5 first ext timeout 4096", 1);
      check("R6 wdo low ext", int'(wdo_o), 0);
      ext_periods(2048);
      check_rst("R5 ext pulse released", 0);
      wdi = ~wdi;
      wait_cyc(4);
      check("R7 wdo high ext", int'(wdo_o), 1);
      ext_periods(1023);
      check_rst("R5 normal ext timeout not yet", 0);
      ext_periods(1);
      check_rst("R5 normal ext timeout 1024", 1);
   endtask

   initial begin
      wait_cyc(3);
      rst_ni = 1'b1;
      t_reset_state();
      t_std_stuck();
      t_std_kick();
      t_fast();
      t_alt_code();
      t_pg_drop();
      t_ext();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule